// File: doc/BRIEF.md
# Per-Channel Delay-Selectable Timeslot Interchanger

This block moves bytes between time-division-multiplexed timeslots. A frame holds `NCH` timeslots and each timeslot carries one byte on every one of `NSTR` parallel streams. Every input byte is stored in a data memory page. For every output stream and timeslot, a connection memory word names the source stream, the source channel and a throughput mode. The block fetches the selected byte and drives it on the output stream.

Three data memory pages rotate, one step per frame. A channel in variable-delay mode takes the freshest copy of its source byte. When the source timeslot has already been stored in the current frame, that copy comes from the current page. Otherwise it comes from the page of the previous frame. The delay of such a channel therefore depends only on the two channel numbers.

A channel in constant-delay mode always reads the page written two frames earlier. Bytes that leave in one output frame therefore always come from one input frame. A third mode marks the output slot for an external test pattern: the byte is forced to zero and a per-stream flag is raised.

A frame pulse marks timeslot 0. When no pulse arrives, the slot counter wraps by itself after `NCH` timeslots. `NSTR` and `NCH` must be powers of two, at least 2.

Top module: `tdm_slot_switch`

## Requirements
- R1: While reset is held, `dout`, `pat_sel` and `cm_rdata` are all zero.
- R2: Mode 00, source channel lower than the output channel: the output carries the source byte stored earlier in the same frame, one cycle after the output timeslot.
- R3: Mode 00, source channel equal to or higher than the output channel: the output carries the source byte from the previous frame.
- R4: Each output stream and timeslot may select any source stream. Which source stream is chosen has no effect on the choice of frame.
- R5: Mode 10: the output always carries the source byte from two frames before the current one.
- R6: The mode is taken from each connection word separately, so channels of one stream may mix the delay modes in one frame.
- R7: Mode 11: the output byte is zero and `pat_sel` for that stream is 1. In all other modes `pat_sel` is 0.
- R8: Mode 01 behaves exactly like mode 00.
- R9: A connection word written at `cm_waddr` can be read back on `cm_rdata` one cycle after `cm_raddr` is presented.
  - The connection memory address is {output stream, output channel}.
  - The connection word is {mode[1:0], source stream, source channel}.
  - With the default parameters, bits 6:5 are the mode, bits 4:3 the source stream and bits 2:0 the source channel.
- R10: A frame pulse makes its timeslot slot 0 of a new frame, even when it arrives before the counter wraps. A short frame stores only the slots it contains.
- R11: Input byte k occupies `din[k*DW +: DW]` and output byte k occupies `dout[k*DW +: DW]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timeslot clock, one timeslot per cycle |
| rst | input | 1 | Synchronous reset, active high |
| fp | input | 1 | Frame pulse, high in timeslot 0 |
| din | input | NSTR*DW | Input bytes of the current timeslot, one per stream |
| dout | output | NSTR*DW | Output bytes, one per stream |
| pat_sel | output | NSTR | Per stream: the output slot is reserved for the test pattern |
| cm_we | input | 1 | Connection memory write enable |
| cm_waddr | input | log2(NSTR)+log2(NCH) | Connection memory write address |
| cm_wdata | input | 2+log2(NSTR)+log2(NCH) | Connection word to write |
| cm_raddr | input | log2(NSTR)+log2(NCH) | Connection memory read address |
| cm_rdata | output | 2+log2(NSTR)+log2(NCH) | Connection word read, registered |

## Verification
The output bytes for timeslot s are registered at the end of cycle s and appear one cycle later. The driver pushes the expected bytes for timeslot s into the queue in that cycle. The monitor pops them shortly after the next rising edge, so each comparison lands in the cycle where the result becomes due. Connection words read back one cycle after the address. A word written in one timeslot first steers the next one, and the bench model applies writes at the same point. Source bytes from frames that were never stored, or from slots cut off by a short frame, are left unchecked rather than guessed.

// File: rtl/tdm_slot_switch.sv
module tdm_slot_switch #(
  parameter int NSTR = 4,
  parameter int NCH  = 8,
  parameter int DW   = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fp,
  input  logic [NSTR*DW-1:0]   din,
  output logic [NSTR*DW-1:0]   dout,
  output logic [NSTR-1:0]      pat_sel,
  input  logic                 cm_we,
  input  logic [$clog2(NSTR)+$clog2(NCH)-1:0]   cm_waddr,
  input  logic [$clog2(NSTR)+$clog2(NCH)+1:0]   cm_wdata,
  input  logic [$clog2(NSTR)+$clog2(NCH)-1:0]   cm_raddr,
  output logic [$clog2(NSTR)+$clog2(NCH)+1:0]   cm_rdata
);
  localparam int SW  = $clog2(NSTR);
  localparam int CW  = $clog2(NCH);
  localparam int AW  = SW + CW;
  localparam int CMW = AW + 2;
  localparam int DMD = 4 * NSTR * NCH;

  logic [CMW-1:0] cm [NSTR*NCH];
  logic [DW-1:0]  dm [DMD];

  logic [CW-1:0] slot_q, slot_cur;
  logic [1:0]    page_q, page_cur, pg_next, pg_p1, pg_p2;
  logic          wrap_q, start;

  assign start    = fp | wrap_q;
  assign pg_next  = (page_q == 2'd2) ? 2'd0 : page_q + 2'd1;
  assign page_cur = start ? pg_next : page_q;
  assign slot_cur = start ? '0 : slot_q;
  assign pg_p1    = (page_cur == 2'd0) ? 2'd2 : page_cur - 2'd1;
  assign pg_p2    = (page_cur == 2'd2) ? 2'd0 : page_cur + 2'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= '0;
      page_q <= 2'd0;
      wrap_q <= 1'b0;
    end else begin
      slot_q <= slot_cur + 1'b1;
      page_q <= page_cur;
      wrap_q <= (slot_cur == CW'(NCH - 1));
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < NSTR; k++)
      dm[{page_cur, SW'(k), slot_cur}] <= din[k*DW +: DW];
  end

  always_ff @(posedge clk) begin
    if (cm_we) cm[cm_waddr] <= cm_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) cm_rdata <= '0;
    else     cm_rdata <= cm[cm_raddr];
  end

  for (genvar k = 0; k < NSTR; k++) begin : g_out
    logic [CMW-1:0] word;
    logic [1:0]     mode;
    logic [SW-1:0]  sst;
    logic [CW-1:0]  sch;
    logic [1:0]     rpage;
    logic [DW-1:0]  rbyte;

    assign word  = cm[{SW'(k), slot_cur}];
    assign mode  = word[CMW-1 -: 2];
    assign sst   = word[CW +: SW];
    assign sch   = word[CW-1:0];
    assign rpage = (mode == 2'b10) ? pg_p2 : ((sch < slot_cur) ? page_cur : pg_p1);
    assign rbyte = dm[{rpage, sst, sch}];

    always_ff @(posedge clk) begin
      if (rst) begin
        dout[k*DW +: DW] <= '0;
        pat_sel[k]       <= 1'b0;
      end else begin
        dout[k*DW +: DW] <= (mode == 2'b11) ? '0 : rbyte;
        pat_sel[k]       <= (mode == 2'b11);
      end
    end
  end
endmodule

// File: rtl/tdm_slot_switch_chk.sv
module tdm_slot_switch_chk #(
  parameter int NSTR = 4,
  parameter int NCH  = 8,
  parameter int DW   = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 fp,
  input logic [NSTR*DW-1:0]   dout,
  input logic [NSTR-1:0]      pat_sel,
  input logic                 cm_we,
  input logic [$clog2(NSTR)+$clog2(NCH)-1:0] cm_waddr,
  input logic [$clog2(NSTR)+$clog2(NCH)+1:0] cm_wdata,
  input logic [$clog2(NSTR)+$clog2(NCH)-1:0] cm_raddr,
  input logic [$clog2(NSTR)+$clog2(NCH)+1:0] cm_rdata,
  input logic [$clog2(NCH)-1:0] slot_q,
  input logic [1:0]           page_q
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (dout == '0 && pat_sel == '0 && cm_rdata == '0));

  assert_cm_readback_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(cm_we) && cm_raddr == $past(cm_waddr)) |=> (cm_rdata == $past(cm_wdata, 2)));

  assert_fp_align_R10: assert property (@(posedge clk) disable iff (rst)
    fp |=> (slot_q == 1));

  assert_page_rotate_R5: assert property (@(posedge clk) disable iff (rst)
    fp |=> (page_q != $past(page_q)));

  assert_page_legal_R5: assert property (@(posedge clk) disable iff (rst)
    page_q != 2'd3);

  for (genvar k = 0; k < NSTR; k++) begin : g_pat
    assert_pat_zero_R7: assert property (@(posedge clk) disable iff (rst)
      pat_sel[k] |-> (dout[k*DW +: DW] == '0));
  end
endmodule

bind tdm_slot_switch tdm_slot_switch_chk #(.NSTR(NSTR), .NCH(NCH), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .fp(fp), .dout(dout), .pat_sel(pat_sel),
  .cm_we(cm_we), .cm_waddr(cm_waddr), .cm_wdata(cm_wdata),
  .cm_raddr(cm_raddr), .cm_rdata(cm_rdata), .slot_q(slot_q), .page_q(page_q)
);

// File: tb/tdm_slot_switch_test.sv
module tdm_slot_switch_test;
  localparam int NSTR = 4, NCH = 8, DW = 8;
  localparam int AW = 5, CMW = 7;

  logic clk = 0, rst = 1, fp = 0, cm_we = 0;
  logic [NSTR*DW-1:0] din = '0, dout;
  logic [NSTR-1:0] pat_sel;
  logic [AW-1:0] cm_waddr = '0, cm_raddr = '0;
  logic [CMW-1:0] cm_wdata = '0, cm_rdata;

  always #4 clk = ~clk;

  tdm_slot_switch #(.NSTR(NSTR), .NCH(NCH), .DW(DW)) uut (
    .clk(clk), .rst(rst), .fp(fp), .din(din), .dout(dout), .pat_sel(pat_sel),
    .cm_we(cm_we), .cm_waddr(cm_waddr), .cm_wdata(cm_wdata),
    .cm_raddr(cm_raddr), .cm_rdata(cm_rdata));

  typedef struct {
    bit                 chk;
    logic [NSTR-1:0]    vld;
    logic [NSTR*DW-1:0] dat;
    logic [NSTR-1:0]    pat;
    logic [NSTR*4-1:0]  req;
  } item_t;

  item_t q[$];
  int tests = 0, fails = 0;
  int fr = -1, sl = 0;
  int flen[64];
  logic [CMW-1:0] cmc[NSTR*NCH];

  function automatic logic [7:0] dfn(int f, int st, int c);
    return 8'(f * 37 + st * 11 + c * 5 + 3);
  endfunction

  // word = {mode[1:0], src stream[1:0], src channel[2:0]} (R9)
  function automatic logic [CMW-1:0] cfg_a(int a);
    int os = a / NCH, oc = a % NCH;
    logic [1:0] m;
    case (os)
      0: m = 2'b00;
      1: m = 2'b10;
      2: m = 2'b01;
      default: m = (oc % 2 == 1) ? 2'b00 : 2'b11;
    endcase
    return {m, 2'((os + 1) % 4), 3'((oc * 3 + os) % 8)};
  endfunction

  // R6: modes mixed channel by channel within each stream
  function automatic logic [CMW-1:0] cfg_b(int a);
    int os = a / NCH, oc = a % NCH;
    logic [1:0] m;
    case (oc % 4)
      0: m = 2'b10;
      1: m = 2'b00;
      2: m = 2'b10;
      default: m = 2'b01;
    endcase
    return {m, 2'(3 - os), 3'((oc + 5) % 8)};
  endfunction

  task automatic step(input bit fpv, input bit we, input int wa, input logic [CMW-1:0] wd);
    item_t it;
    @(negedge clk);
    if (fpv) begin
      if (fr >= 0) flen[fr] = sl;
      fr++;
      sl = 0;
    end else if (fr >= 0) sl++;
    fp = fpv;
    cm_we = we;
    cm_waddr = AW'(wa);
    cm_wdata = wd;
    for (int st = 0; st < NSTR; st++)
      din[st*DW +: DW] = (fr >= 0) ? dfn(fr, st, sl) : 8'hA5;
    it.chk = (fr >= 0);
    it.vld = '0; it.dat = '0; it.pat = '0; it.req = '0;
    if (fr >= 0) begin
      for (int k = 0; k < NSTR; k++) begin
        logic [CMW-1:0] w = cmc[k*NCH + sl];
        int md = int'(w[6:5]);
        int ss = int'(w[4:3]);
        int sc = int'(w[2:0]);
        int sf;
        int rq;
        if (md == 3) begin
          it.vld[k] = 1; it.pat[k] = 1; it.dat[k*DW +: DW] = '0; rq = 7;   // R7
        end else begin
          if (md == 2) begin sf = fr - 2; rq = 5; end                       // R5
          else if (sc < sl) begin sf = fr; rq = (md == 1) ? 8 : 2; end      // R2, R8
          else begin sf = fr - 1; rq = (md == 1) ? 8 : 3; end               // R3, R8
          it.vld[k] = (sf >= 0) && ((sf == fr) || (sc < flen[sf]));         // R10
          it.dat[k*DW +: DW] = (sf >= 0) ? dfn(sf, ss, sc) : 8'h00;
        end
        it.req[k*4 +: 4] = 4'(rq);
      end
    end
    q.push_back(it);
    if (we) cmc[wa] = wd;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // monitor: R4 and R11 on every compare (cross-stream sources, byte lanes)
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        it = q.pop_front();
        if (it.chk)
          for (int k = 0; k < NSTR; k++)
            if (it.vld[k]) begin
              tests++;
              if (dout[k*DW +: DW] !== it.dat[k*DW +: DW] || pat_sel[k] !== it.pat[k]) begin
                fails++;
                $display("FAIL R%0d/R4/R11 stream %0d act=%h/%b exp=%h/%b", it.req[k*4 +: 4], k,
                         dout[k*DW +: DW], pat_sel[k], it.dat[k*DW +: DW], it.pat[k]);
              end
            end
      end
    end
  end

  initial begin
    #(200000 * 8);
    tests++; fails++;
    $display("FAIL watchdog act=running exp=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) flen[i] = NCH;
    repeat (3) @(negedge clk);
    check("R1 dout", 32'(dout), 32'h0);
    check("R1 pat_sel", 32'(pat_sel), 32'h0);
    check("R1 cm_rdata", 32'(cm_rdata), 32'h0);
    rst = 0;
    for (int a = 0; a < NSTR*NCH; a++) step(0, 1, a, cfg_a(a));
    for (int i = 0; i < 4; i++) begin
      int a = (i * 9 + 4) % (NSTR*NCH);
      cm_raddr = AW'(a);
      step(0, 0, 0, '0);
      check("R9 readback", 32'(cm_rdata), 32'(cmc[a]));
    end
    for (int f = 0; f < 6; f++)
      for (int s = 0; s < NCH; s++) step(s == 0, 0, 0, '0);
    for (int s = 0; s < 5; s++) step(s == 0, 0, 0, '0);   // R10 short frame
    for (int f = 0; f < 3; f++)
      for (int s = 0; s < NCH; s++) step(s == 0, 0, 0, '0);
    for (int f = 0; f < 4; f++)
      for (int s = 0; s < NCH; s++) step(s == 0, 1, f*NCH + s, cfg_b(f*NCH + s));
    for (int f = 0; f < 4; f++)
      for (int s = 0; s < NCH; s++) step(s == 0, 0, 0, '0);
    repeat (3) @(posedge clk);
    #3;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule